// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side it watches the UART's serial output. For every zero bit it emits one short active-high pulse at the start of that bit period on the infrared output. One bits produce no pulse. The pulse width comes from one of two modes. In the normal mode it lasts three 16x baud ticks, which is 3/16 of a bit. In the low-power mode it lasts three periods of a separate low-power reference tick, whatever the bit rate.

On the receive side, an active-low pulse from the infrared receiver is synchronised and its leading (falling) edge is detected. The reconstructed serial line is then driven low for one full bit period of sixteen baud ticks. While infrared operation is off, the plain wire pins pass straight through and both infrared paths are quiet. A test loopback, which needs two controls together, routes the inverted infrared output into the decoder in place of the external receiver.

The encoder is a three-state machine: `ENC_IDLE` waits for a zero bit, `ENC_PULSE` drives the pulse, and `ENC_GAP` waits out the rest of the bit period. Its transitions are:
- start (`ENC_IDLE`→`ENC_PULSE`): on a baud tick with the serial bit low.
- pulse_done (`ENC_PULSE`→`ENC_GAP`): on the third baud tick, or in low-power mode on the third reference tick.
- next_zero (`ENC_GAP` or `ENC_PULSE`→`ENC_PULSE`): at the 16th tick with the serial bit low.
- bit_done (→`ENC_IDLE`): at the 16th tick with the serial bit high.
- disable (any state →`ENC_IDLE`): when the codec is inactive.

The decoder has two states, `DEC_IDLE` and `DEC_LOW`. Its transitions are:
- edge (`DEC_IDLE`→`DEC_LOW`): on a detected falling edge.
- window_end (`DEC_LOW`→`DEC_IDLE`): on the 16th tick.
- rearm (`DEC_LOW`→`DEC_LOW`): when a new edge arrives on the 16th tick.
- disable (→`DEC_IDLE`): when the codec is inactive.

Top module: `sir_codec`

## Requirements
- R1: In normal mode, a zero bit on `tx_serial` makes `sir_out` high, starting in the cycle after the baud tick that begins the bit. The pulse falls at the third following baud tick, so it covers exactly three `baud16_tick` strobes.
- R2: Each zero bit yields exactly one `sir_out` pulse and each one bit yields none; a bit period spans sixteen baud ticks.
- R3: In low-power mode (`lowpwr_mode`=1), the pulse covers exactly three `lp_tick` strobes, independent of the baud tick rate.
- R4: With `sir_en`=0, `sir_out` stays 0, `txd_pin` equals `tx_serial`, `rx_serial` equals `rxd_pin`, and activity on `sir_in_n` has no effect on `rx_serial`.
- R5: With `uart_en`=0, `sir_en` has no effect: the block behaves exactly as in R4.
- R6: While active (`uart_en`=1 and `sir_en`=1), `txd_pin` is held at 1 and `rxd_pin` has no effect on `rx_serial`.
- R7: While active without loopback, a falling edge on `sir_in_n` drives `rx_serial` low from the third clock edge after the edge onward. It stays low for exactly sixteen `baud16_tick` strobes, then returns to 1.
- R8: When `loop_en`=1 and `test_ovr`=1, the decoder sees the inverse of `sir_out` and ignores `sir_in_n`, so `rx_serial` sampled mid-bit equals the sent bit. With only one of these two controls set, there is no loopback.
- R9: After reset, `sir_out` is 0 and, with the controls low, `txd_pin` follows `tx_serial` and `rx_serial` follows `rxd_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud16_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| uart_en | input | 1 | Overall UART enable |
| sir_en | input | 1 | Infrared mode enable (effective only with `uart_en`) |
| lowpwr_mode | input | 1 | 1: pulse width from `lp_tick`; 0: 3/16 bit |
| loop_en | input | 1 | Loopback request |
| test_ovr | input | 1 | Test override; loopback needs both this and `loop_en` |
| tx_serial | input | 1 | Serial stream from the UART transmitter |
| rxd_pin | input | 1 | Plain wire receive pin |
| sir_in_n | input | 1 | Infrared receiver input, active-low pulses |
| sir_out | output | 1 | Infrared transmitter drive, active-high pulses |
| txd_pin | output | 1 | Plain wire transmit pin |
| rx_serial | output | 1 | Serial stream to the UART receiver |

## Verification
The embedded properties watch the pulse widths on every cycle. A normal-mode pulse must have spanned three baud ticks and a low-power pulse three reference ticks. A pulse may start only on a baud tick with the serial bit low. The encoder and decoder must fall quiet one cycle after the codec goes inactive, and a reconstructed low must begin only while active. Other behaviour only the bench scenarios can show: one pulse per zero bit across whole frames, the pass-through and marking of the plain pins, the three-edge decoder latency, the sixteen-tick low window, and loopback engaging only with both controls set.

// File: rtl/sir_pkg.sv
package sir_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE  = 2'd0,
        ENC_PULSE = 2'd1,
        ENC_GAP   = 2'd2
    } enc_state_e;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_LOW  = 1'b1
    } dec_state_e;

endpackage

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT   = 16,
    parameter int PULSE_TICKS     = 3,
    parameter int LP_PULSE_TICKS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lp_mode,
    input  logic bd_tick,
    input  logic lp_tick,
    input  logic tx_bit,
    output logic sir_pulse
);
    localparam int CW  = $clog2(TICKS_PER_BIT);
    localparam int LPW = $clog2(LP_PULSE_TICKS + 1);
    localparam int KW  = $clog2(TICKS_PER_BIT + 2);
    localparam logic [CW-1:0]  BIT_LAST   = CW'(TICKS_PER_BIT - 1);
    localparam logic [CW-1:0]  PULSE_LAST = CW'(PULSE_TICKS - 1);
    localparam logic [LPW-1:0] LP_LAST    = LPW'(LP_PULSE_TICKS - 1);

    enc_state_e     state_q, state_d;
    logic [CW-1:0]  bit_q, bit_d;
    logic [LPW-1:0] lp_q, lp_d;
    logic           bit_end;

    assign bit_end = bd_tick && (bit_q == BIT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_IDLE;
            bit_q   <= '0;
            lp_q    <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            lp_q    <= lp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        lp_d    = lp_q;
        unique case (state_q)
            ENC_IDLE: begin
                if (bd_tick && !tx_bit) begin
                    state_d = ENC_PULSE;
                    bit_d   = '0;
                    lp_d    = '0;
                end
            end
            ENC_PULSE: begin
                if (bd_tick) bit_d = bit_q + 1'b1;
                if (lp_tick && (lp_q != LP_LAST)) lp_d = lp_q + 1'b1;
                if (bit_end) begin
                    bit_d   = '0;
                    lp_d    = '0;
                    state_d = tx_bit ? ENC_IDLE : ENC_PULSE;
                end else if (!lp_mode && bd_tick && (bit_q == PULSE_LAST)) begin
                    state_d = ENC_GAP;
                end else if (lp_mode && lp_tick && (lp_q == LP_LAST)) begin
                    state_d = ENC_GAP;
                end
            end
            ENC_GAP: begin
                if (bd_tick) bit_d = bit_q + 1'b1;
                if (bit_end) begin
                    bit_d   = '0;
                    lp_d    = '0;
                    state_d = tx_bit ? ENC_IDLE : ENC_PULSE;
                end
            end
            default: state_d = ENC_IDLE;
        endcase
        if (!active) begin
            state_d = ENC_IDLE;
            bit_d   = '0;
            lp_d    = '0;
        end
    end

    always_comb begin
        sir_pulse = (state_q == ENC_PULSE);
    end

    // Checker counters: ticks seen while the pulse is high
    logic [KW-1:0] chk_bd;
    logic [KW-1:0] chk_lp;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_bd <= '0;
            chk_lp <= '0;
        end else if (!sir_pulse) begin
            chk_bd <= '0;
            chk_lp <= '0;
        end else begin
            if (bd_tick && (chk_bd != KW'(TICKS_PER_BIT + 1))) chk_bd <= chk_bd + 1'b1;
            if (lp_tick && (chk_lp != KW'(TICKS_PER_BIT + 1))) chk_lp <= chk_lp + 1'b1;
        end
    end

    a_r1_normal_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sir_pulse) && active && !lp_mode) |-> (chk_bd == KW'(PULSE_TICKS)));

    a_r3_lowpower_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sir_pulse) && active && lp_mode) |->
            ((chk_lp == KW'(LP_PULSE_TICKS)) || (chk_bd == KW'(TICKS_PER_BIT))));

    a_r2_start_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sir_pulse) |-> ($past(bd_tick) && !$past(tx_bit)));

    a_r4_enc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sir_pulse);

endmodule

// File: rtl/sir_pulse_dec.sv
module sir_pulse_dec
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bd_tick,
    input  logic pulse_n,
    output logic dec_low
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam int KW = $clog2(2 * TICKS_PER_BIT + 2);
    localparam logic [CW-1:0] BIT_LAST = CW'(TICKS_PER_BIT - 1);

    logic [SYNC_STAGES:0] sh_q;
    logic                 fall;
    dec_state_e           state_q, state_d;
    logic [CW-1:0]        cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pulse_n};
    end

    assign fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DEC_IDLE: begin
                if (fall) begin
                    state_d = DEC_LOW;
                    cnt_d   = '0;
                end
            end
            DEC_LOW: begin
                if (bd_tick) cnt_d = cnt_q + 1'b1;
                if (bd_tick && (cnt_q == BIT_LAST)) begin
                    cnt_d   = '0;
                    state_d = fall ? DEC_LOW : DEC_IDLE;
                end
            end
            default: state_d = DEC_IDLE;
        endcase
        if (!active) begin
            state_d = DEC_IDLE;
            cnt_d   = '0;
        end
    end

    always_comb begin
        dec_low = (state_q == DEC_LOW);
    end

    // Checker counter: baud ticks spent low in one stretch
    logic [KW-1:0] chk_low;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           chk_low <= '0;
        else if (!dec_low)                                    chk_low <= '0;
        else if (bd_tick && (chk_low != KW'(2 * TICKS_PER_BIT + 1))) chk_low <= chk_low + 1'b1;
    end

    a_r7_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dec_low |-> (chk_low <= KW'(2 * TICKS_PER_BIT)));

    a_r7_entry_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_low) |-> $past(active));

    a_r4_dec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !dec_low);

endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud16_tick,
    input  logic lp_tick,
    input  logic uart_en,
    input  logic sir_en,
    input  logic lowpwr_mode,
    input  logic loop_en,
    input  logic test_ovr,
    input  logic tx_serial,
    input  logic rxd_pin,
    input  logic sir_in_n,
    output logic sir_out,
    output logic txd_pin,
    output logic rx_serial
);
    logic active;
    logic loop_sel;
    logic enc_pulse;
    logic dec_in_n;
    logic dec_low;

    assign active   = uart_en & sir_en;
    assign loop_sel = loop_en & test_ovr;

    sir_pulse_enc #(
        .TICKS_PER_BIT  (TICKS_PER_BIT),
        .PULSE_TICKS    (PULSE_TICKS),
        .LP_PULSE_TICKS (LP_PULSE_TICKS)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .lp_mode   (lowpwr_mode),
        .bd_tick   (baud16_tick),
        .lp_tick   (lp_tick),
        .tx_bit    (tx_serial),
        .sir_pulse (enc_pulse)
    );

    assign dec_in_n = loop_sel ? ~enc_pulse : sir_in_n;

    sir_pulse_dec #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .bd_tick (baud16_tick),
        .pulse_n (dec_in_n),
        .dec_low (dec_low)
    );

    assign sir_out   = enc_pulse;
    assign txd_pin   = active | tx_serial;
    assign rx_serial = active ? ~dec_low : rxd_pin;

endmodule

// File: tb/sir_codec_bench.sv
`timescale 1ns/1ps
module sir_codec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud16_tick = 1'b0, lp_tick = 1'b0;
    logic uart_en = 1'b0, sir_en = 1'b0, lowpwr_mode = 1'b0;
    logic loop_en = 1'b0, test_ovr = 1'b0;
    logic tx_serial = 1'b1, rxd_pin = 1'b1, sir_in_n = 1'b1;
    logic sir_out, txd_pin, rx_serial;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    int bdiv = 0, ldiv = 0;

    always #4 clk = ~clk;

    sir_codec u_sir_codec (
        .clk(clk), .rst_n(rst_n), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
        .uart_en(uart_en), .sir_en(sir_en), .lowpwr_mode(lowpwr_mode),
        .loop_en(loop_en), .test_ovr(test_ovr), .tx_serial(tx_serial),
        .rxd_pin(rxd_pin), .sir_in_n(sir_in_n), .sir_out(sir_out),
        .txd_pin(txd_pin), .rx_serial(rx_serial)
    );

    // Tick generators: baud tick every 4 cycles, reference tick every 5
    always @(negedge clk) begin
        bdiv <= (bdiv == 3) ? 0 : bdiv + 1;
        ldiv <= (ldiv == 4) ? 0 : ldiv + 1;
        baud16_tick <= (bdiv == 3);
        lp_tick     <= (ldiv == 4);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int actual, input int expected);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    function automatic int exp_width(input bit b, input bit act);
        return (act && !b) ? 3 : 0;
    endfunction

    function automatic int exp_rises(input bit b, input bit act);
        return (act && !b) ? 1 : 0;
    endfunction

    function automatic bit exp_mid(input bit b, input bit act, input bit lp, input bit rxd);
        if (!act) return rxd;
        return lp ? b : 1'b1;
    endfunction

    // Called at a negedge just after a baud tick edge; returns at the same phase
    task automatic send_bit(input bit b);
        bit act = uart_en && sir_en;
        bit lp  = loop_en && test_ovr;
        int n = 0, wbd = 0, wlp = 0, rises = 0, bad_tx = 0, bad_rx = 0;
        bit prev = 1'b0;
        bit mid = 1'b1, mid_exp = 1'b1;
        string ptag = lowpwr_mode ? "R3" : "R1";
        string ptag_off = (uart_en == 1'b0) ? "R5" : "R4";
        tx_serial = b;
        while (n < 16) begin
            @(negedge clk);
            if (!(act && !lp)) sir_in_n = $urandom_range(0, 1);
            else               sir_in_n = 1'b1;
            rxd_pin = $urandom_range(0, 1);
            #1;
            if (sir_out && baud16_tick) wbd++;
            if (sir_out && lp_tick)     wlp++;
            if (sir_out && !prev)       rises++;
            prev = sir_out;
            if (txd_pin !== (act ? 1'b1 : tx_serial)) bad_tx++;
            if (!act && (rx_serial !== rxd_pin))      bad_rx++;
            if (baud16_tick) begin
                n++;
                if (n == 8) begin
                    mid = rx_serial;
                    mid_exp = exp_mid(b, act, lp, rxd_pin);
                end
            end
        end
        @(negedge clk);
        sir_in_n = 1'b1;
        if (act) begin
            check((lowpwr_mode ? wlp : wbd) == exp_width(b, act), ptag, "pulse width in ticks",
                  lowpwr_mode ? wlp : wbd, exp_width(b, act));
            check(rises == exp_rises(b, act), "R2", "pulses per bit", rises, exp_rises(b, act));
            check(bad_tx == 0, "R6", "txd_pin marking mismatches", bad_tx, 0);
            check(mid == mid_exp, lp ? "R8" : "R6", "rx_serial mid-bit", mid, mid_exp);
        end else begin
            check(rises == 0, ptag_off, "sir_out pulses while inactive", rises, 0);
            check(bad_tx == 0, ptag_off, "txd_pin pass-through mismatches", bad_tx, 0);
            check(bad_rx == 0, ptag_off, "rx_serial pass-through mismatches", bad_rx, 0);
        end
    endtask

    task automatic align();
        @(negedge clk);
        while (!baud16_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] data);
        align();
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(data[i]);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic set_cfg(input bit ue, input bit se, input bit lpm, input bit le, input bit to);
        @(negedge clk);
        uart_en = ue; sir_en = se; lowpwr_mode = lpm; loop_en = le; test_ovr = to;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int seed_dummy;
        int lowcnt;
        seed_dummy = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(sir_out == 1'b0, "R9", "sir_out after reset", sir_out, 0);
        check(txd_pin == tx_serial, "R9", "txd_pin after reset", txd_pin, tx_serial);
        rxd_pin = 1'b0; #1;
        check(rx_serial == rxd_pin, "R9", "rx_serial after reset", rx_serial, rxd_pin);

        // R4: infrared disabled, UART enabled
        set_cfg(1, 0, 0, 1, 1);
        send_frame(8'h00);
        // R5: UART disabled, infrared enable set
        set_cfg(0, 1, 0, 1, 1);
        send_frame(8'h5A);
        // R1, R2, R6, R8: normal mode with loopback
        set_cfg(1, 1, 0, 1, 1);
        send_frame(8'h00);
        send_frame(8'hA5);
        send_frame(8'hFF);
        // R8: only one loopback control set
        set_cfg(1, 1, 0, 1, 0);
        send_frame(8'h0F);
        set_cfg(1, 1, 0, 0, 1);
        send_frame(8'h33);
        // R3: low-power mode with loopback
        set_cfg(1, 1, 1, 1, 1);
        send_frame(8'h00);
        send_frame(8'h96);

        // R7: external pulse, latency and low window
        set_cfg(1, 1, 0, 0, 0);
        tx_serial = 1'b1;
        repeat (80) @(negedge clk);
        sir_in_n = 1'b0;
        @(negedge clk); @(negedge clk);
        #1;
        check(rx_serial == 1'b1, "R7", "rx_serial two edges after pulse", rx_serial, 1);
        @(negedge clk);
        sir_in_n = 1'b1;
        #1;
        check(rx_serial == 1'b0, "R7", "rx_serial three edges after pulse", rx_serial, 0);
        lowcnt = 0;
        for (int k = 0; k < 200 && rx_serial == 1'b0; k++) begin
            if (baud16_tick) lowcnt++;
            @(negedge clk);
            #1;
        end
        check(lowcnt == 16, "R7", "baud ticks with rx_serial low", lowcnt, 16);
        // R6: rxd_pin toggling while active with quiet infrared input
        lowcnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rxd_pin = ~rxd_pin;
            #1;
            if (rx_serial != 1'b1) lowcnt++;
        end
        check(lowcnt == 0, "R6", "rx_serial disturbed by rxd_pin", lowcnt, 0);

        // Random frames over random configurations
        for (int f = 0; f < 24; f++) begin
            bit ue = ($urandom_range(0, 7) != 0);
            bit se = ($urandom_range(0, 7) != 0);
            bit lpm = $urandom_range(0, 1);
            bit le = ($urandom_range(0, 3) != 0);
            bit to = ($urandom_range(0, 3) != 0);
            set_cfg(ue, se, lpm, le, to);
            send_frame(8'($urandom_range(0, 255)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule